// File: doc/BRIEF.md
# Shared-Bus Accumulator Computer

A very small stored-program computer. Every register transfer passes over one 8-bit internal bus, and exactly one source drives that bus in any step. The block holds a program counter, a memory address register, an instruction register, an accumulator, an operand register, an add/subtract unit and a 32-word by 8-bit memory. On reset, the memory is loaded from a constant program parameter. A four-position one-hot ring sequencer splits every instruction into four steps. The block has no inputs other than clock and reset. It shows the accumulator, a halt flag and a sticky flag that reports if two bus drivers were ever enabled together.

Each instruction word has two fields. The upper three bits are the operation and the lower five bits are a direct memory address. The four steps of an instruction work as follows:

- In the first step, the program counter is copied into the address register.
- In the second step, the memory word at that address is latched as the instruction and the program counter advances.
- The third and fourth steps carry out the operation.

Top module: `acc_bus_cpu`

## Requirements
- R1: While reset is high, and in the first cycle after it, the accumulator reads 0, the halt flag is 0 and the conflict flag is 0. The memory holds the program parameter, with word i at bits [8i+7:8i].
- R2: Fetching starts at address 0. Each instruction takes exactly four clock cycles. Without a jump, the program counter advances by one per instruction and wraps modulo 32.
- R3: Opcode 000 (load) copies memory[addr] into the accumulator. The new value is visible after the third clock of the instruction.
- R4: Opcode 010 (add) latches memory[addr] into the operand register in the third step. In the fourth step it writes A + operand, modulo 256, into the accumulator.
- R5: Opcode 011 (subtract) writes A + ~operand + 1, modulo 256, into the accumulator in the fourth step.
- R6: Opcode 001 (store) writes the accumulator into memory[addr] in the third step. Later reads of that address return the stored value.
- R7: Opcode 100 (jump) makes addr the address of the next instruction.
- R8: Opcode 101 (branch) acts as a jump when the accumulator is zero. Otherwise it acts as no operation.
- R9: Opcode 111 (halt) raises the halt flag after the third clock of the instruction. The halt flag then stays high, and the sequencer and accumulator stay frozen until reset.
- R10: At most one bus source is enabled in any cycle, so the conflict flag never rises.
- R11: Opcode 110 leaves the accumulator unchanged. The accumulator changes only in steps that load it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_out | output | 8 | Accumulator contents |
| halted | output | 1 | High once a halt instruction has executed |
| bus_conflict | output | 1 | Sticky: two bus drivers were enabled in the same cycle |

## Verification
Some cycles combine two functions.

- In the second step, the memory drives the bus from the address register while the program counter increments.
- In the third step of a store, the accumulator drives the bus while the memory captures it at the instruction's own address.
- A taken branch in the third step depends on an accumulator value that the preceding subtract wrote in its fourth step.

Sixteen copies of the block run programs built in the bench. In a quarter of them, the subtract gives exactly zero, so the branch, the jump and a read-back of the stored word all execute. At every instruction boundary, an instruction-level interpreter in the bench supplies the expected accumulator and halt state.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_LDA = 3'b000,
    OP_STA = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_JMP = 3'b100,
    OP_BRA = 3'b101,
    OP_NOP = 3'b110,
    OP_HLT = 3'b111
  } opcode_e;

  localparam int OPC_W   = 3;
  localparam int NUM_SRC = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_MEM = 1;
  localparam int SRC_IRA = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_ALU = 4;

  typedef struct packed {
    logic [NUM_SRC-1:0] drv;
    logic               ld_mar;
    logic               ld_ir;
    logic               inc_pc;
    logic               ld_pc;
    logic               ld_b;
    logic               ld_a;
    logic               mem_wr;
    logic               use_mar;
    logic               set_halt;
    logic               sub;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opcode_e    opcode,
  input  logic       acc_zero,
  output logic [3:0] step,
  output ctrl_t      ctl,
  output logic       halted
);

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= 4'b0001;
      halted <= 1'b0;
    end else begin
      if (ctl.set_halt) halted <= 1'b1;
      if (!halted)      step   <= {step[2:0], step[3]};
    end
  end

  always_comb begin
    ctl = '0;
    if (!halted) begin
      if (step[0]) begin
        ctl.drv[SRC_PC] = 1'b1;
        ctl.ld_mar      = 1'b1;
      end
      if (step[1]) begin
        ctl.drv[SRC_MEM] = 1'b1;
        ctl.use_mar      = 1'b1;
        ctl.ld_ir        = 1'b1;
        ctl.inc_pc       = 1'b1;
      end
      if (step[2]) begin
        unique case (opcode)
          OP_LDA: begin ctl.drv[SRC_MEM] = 1'b1; ctl.ld_a   = 1'b1; end
          OP_STA: begin ctl.drv[SRC_ACC] = 1'b1; ctl.mem_wr = 1'b1; end
          OP_ADD, OP_SUB: begin ctl.drv[SRC_MEM] = 1'b1; ctl.ld_b = 1'b1; end
          OP_JMP: begin ctl.drv[SRC_IRA] = 1'b1; ctl.ld_pc  = 1'b1; end
          OP_BRA: begin
            if (acc_zero) begin
              ctl.drv[SRC_IRA] = 1'b1;
              ctl.ld_pc        = 1'b1;
            end
          end
          OP_HLT: ctl.set_halt = 1'b1;
          default: ;
        endcase
      end
      if (step[3]) begin
        if (opcode == OP_ADD || opcode == OP_SUB) begin
          ctl.drv[SRC_ALU] = 1'b1;
          ctl.ld_a         = 1'b1;
          ctl.sub          = (opcode == OP_SUB);
        end
      end
    end
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(step)) else $error("ring lost its token"); // R2

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted) else $error("halt dropped"); // R9

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(step)) else $error("ring moved while halted"); // R9

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W*(2**ADDR_W)-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 2**ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= INIT[i*DATA_W +: DATA_W];
    end else if (wr_en) begin
      words[addr] <= wr_data;
    end
  end

  assign rd_data = words[addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> words[$past(addr)] == $past(wr_data)) else $error("store lost"); // R6

endmodule

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0][W-1:0] src,
  input  logic [N-1:0]      en,
  output logic [W-1:0]      bus,
  output logic              multi
);

  logic [N-1:0][W-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : gen_gate
    assign gated[i] = src[i] & {W{en[i]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end

  assign multi = (en & (en - 1'b1)) != '0;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en)) else $error("two bus drivers"); // R10

endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W*(2**ADDR_W)-1:0] PROGRAM = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] acc_out,
  output logic              halted,
  output logic              bus_conflict
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc, mar, mem_addr;
  logic [DATA_W-1:0] ir, acc, opnd, bus, mem_rd, alu_y;
  logic [3:0]        step;
  logic              multi;
  ctrl_t             ctl;
  logic [NUM_SRC-1:0][DATA_W-1:0] src;

  function automatic logic [DATA_W-1:0] alu_op(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic sub);
    return a + (sub ? ~b : b) + {{(DATA_W-1){1'b0}}, sub};
  endfunction

  acc_cpu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode_e'(ir[DATA_W-1 -: OPC_W])),
    .acc_zero (acc == '0),
    .step     (step),
    .ctl      (ctl),
    .halted   (halted)
  );

  assign mem_addr = ctl.use_mar ? mar : ir[ADDR_W-1:0];

  acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INIT(PROGRAM)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .addr    (mem_addr),
    .wr_en   (ctl.mem_wr),
    .wr_data (bus),
    .rd_data (mem_rd)
  );

  assign alu_y        = alu_op(acc, opnd, ctl.sub);
  assign src[SRC_PC]  = {{PAD_W{1'b0}}, pc};
  assign src[SRC_MEM] = mem_rd;
  assign src[SRC_IRA] = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
  assign src[SRC_ACC] = acc;
  assign src[SRC_ALU] = alu_y;

  acc_cpu_bus #(.W(DATA_W), .N(NUM_SRC)) u_bus (
    .clk   (clk),
    .rst   (rst),
    .src   (src),
    .en    (ctl.drv),
    .bus   (bus),
    .multi (multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc           <= '0;
      mar          <= '0;
      ir           <= '0;
      acc          <= '0;
      opnd         <= '0;
      bus_conflict <= 1'b0;
    end else begin
      if (ctl.ld_mar) mar  <= bus[ADDR_W-1:0];
      if (ctl.ld_ir)  ir   <= bus;
      if (ctl.ld_b)   opnd <= bus;
      if (ctl.ld_a)   acc  <= bus;
      if (ctl.ld_pc)       pc <= bus[ADDR_W-1:0];
      else if (ctl.inc_pc) pc <= pc + 1'b1;
      if (multi) bus_conflict <= 1'b1;
    end
  end

  assign acc_out = acc;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.inc_pc |=> pc == $past(pc) + 1'b1) else $error("pc did not advance"); // R2

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctl.ld_pc |=> pc == $past(ir[ADDR_W-1:0])) else $error("jump target wrong"); // R7

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctl.ld_a |=> acc == $past(acc)) else $error("accumulator drifted"); // R11

endmodule

// File: tb/acc_bus_cpu_tb.sv
module acc_bus_cpu_tb;

  localparam int NI = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] ins(input int op, input int ad);
    return {op[2:0], ad[4:0]};
  endfunction

  function automatic logic [255:0] prog_for(input int g);
    logic [255:0] p;
    int x, y, z, w;
    x = (g * 37 + 11) % 256;
    y = (g * 89 + 200) % 256;
    z = (g % 4 == 0) ? (x + y) % 256 : (g * 53 + 1) % 256;
    w = (g * 29 + 77) % 256;
    p = '0;
    p[0*8 +: 8]  = ins(0, 20);
    p[1*8 +: 8]  = ins(2, 21);
    p[2*8 +: 8]  = ins(1, 24);
    p[3*8 +: 8]  = ins(3, 22);
    p[4*8 +: 8]  = ins(5, 7);
    p[5*8 +: 8]  = ins(0, 23);
    p[6*8 +: 8]  = ins(7, 0);
    p[7*8 +: 8]  = ins(6, 0);
    p[8*8 +: 8]  = ins(4, 10);
    p[9*8 +: 8]  = ins(0, 23);
    p[10*8 +: 8] = ins(2, 24);
    p[11*8 +: 8] = ins(7, 0);
    p[20*8 +: 8] = x[7:0];
    p[21*8 +: 8] = y[7:0];
    p[22*8 +: 8] = z[7:0];
    p[23*8 +: 8] = w[7:0];
    return p;
  endfunction

  logic [7:0] a_o [NI];
  logic       h_o [NI];
  logic       c_o [NI];

  for (genvar g = 0; g < NI; g++) begin : gen_dut
    logic [7:0] a_w;
    logic       h_w, c_w;
    acc_bus_cpu #(.DATA_W(8), .ADDR_W(5), .PROGRAM(prog_for(g))) u_dut (
      .clk          (clk),
      .rst          (rst),
      .acc_out      (a_w),
      .halted       (h_w),
      .bus_conflict (c_w)
    );
    assign a_o[g] = a_w;
    assign h_o[g] = h_w;
    assign c_o[g] = c_w;
  end

  task automatic chk(input bit ok, input string tag, input int g, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s copy %0d: actual %0d expected %0d", tag, g, act, exp);
    end
  endtask

  logic [7:0] mm [NI][32];
  logic [4:0] mpc [NI];
  logic [7:0] ma [NI];
  bit         mh [NI];

  initial begin
    for (int g = 0; g < NI; g++) begin
      logic [255:0] p;
      p = prog_for(g);
      for (int i = 0; i < 32; i++) mm[g][i] = p[i*8 +: 8];
      mpc[g] = '0;
      ma[g]  = '0;
      mh[g]  = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < NI; g++) begin
      chk(a_o[g] == 8'd0, "R1 reset accumulator", g, a_o[g], 0);
      chk(h_o[g] == 1'b0, "R1 reset halt", g, h_o[g], 0);
      chk(c_o[g] == 1'b0, "R1 reset conflict", g, c_o[g], 0);
    end
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      string tags [NI];
      repeat (4) @(posedge clk);
      @(negedge clk);
      for (int g = 0; g < NI; g++) begin
        logic [7:0] w;
        logic [4:0] ad;
        if (mh[g]) begin
          tags[g] = "R9 frozen after halt";
        end else begin
          w  = mm[g][mpc[g]];
          ad = w[4:0];
          mpc[g] = mpc[g] + 5'd1;
          case (w[7:5])
            3'd0: begin ma[g] = mm[g][ad]; tags[g] = "R2/R3 load"; end
            3'd1: begin mm[g][ad] = ma[g]; tags[g] = "R2/R6 store"; end
            3'd2: begin ma[g] = ma[g] + mm[g][ad]; tags[g] = "R2/R4 add"; end
            3'd3: begin ma[g] = ma[g] - mm[g][ad]; tags[g] = "R2/R5 subtract"; end
            3'd4: begin mpc[g] = ad; tags[g] = "R2/R7 jump"; end
            3'd5: begin if (ma[g] == 8'd0) mpc[g] = ad; tags[g] = "R2/R8 branch"; end
            3'd6: tags[g] = "R2/R11 no-op";
            default: begin mh[g] = 1'b1; tags[g] = "R9 halt"; end
          endcase
        end
        chk(a_o[g] == ma[g], tags[g], g, a_o[g], ma[g]);
        chk(h_o[g] == mh[g], "R9 halt flag", g, h_o[g], mh[g]);
        chk(c_o[g] == 1'b0, "R10 bus conflict", g, c_o[g], 0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100us;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule